// File: doc/BRIEF.md
# Masked Vector Lane Writeback

This block forms the final 512-bit destination value of a packed 64-bit vector operation. The lane datapaths have already produced one result word per lane, and each lane also reports its own exception flags. This block decides which lanes are written and which keep or clear their old contents. It can replace every lane's data with lane 0's result, and it clears every lane above the active vector length.

It also checks a reserved 4-bit field carried with the operation. Any value other than all ones is an undefined-instruction fault. A faulting operation writes nothing: the old destination passes through unchanged and no exception flags are raised. The result is captured on a valid strobe and presented one cycle later together with a single-cycle output-valid pulse.

Top module: `vec_lane_wb`

## Requirements
- R1: After reset is asserted, valid_o, dst_o, exc_o and ud_o are all zero.
- R2: valid_o is high in exactly the cycle after a cycle with valid_i high. dst_o, exc_o and ud_o change only on such a capture and hold their values otherwise.
- R3: vl_sel_i selects the active lane count: 0 gives 2 lanes (128 bits), 1 gives 4 lanes (256 bits), and 2 or 3 give 8 lanes (512 bits). Lane j occupies bits 64j+63 down to 64j of every vector port.
- R4: Every destination bit at or above the active vector length is zero in a non-faulting result.
- R5: With mask_en_i low, every active lane takes its result word, whatever mask_i holds.
- R6: With mask_en_i high, an active lane whose mask_i bit is 1 takes its result word.
- R7: With mask_en_i high and zero_mode_i low, an active lane whose mask bit is 0 keeps its old_dst_i word.
- R8: With mask_en_i high and zero_mode_i high, an active lane whose mask bit is 0 becomes zero.
- R9: When bcast_i and src_mem_i are both high, every written lane takes lane 0's result word and lane 0's exception flags. bcast_i with src_mem_i low has no effect.
- R10: A rsvd_i value other than 4'b1111 sets ud_o and leaves dst_o equal to old_dst_i and exc_o zero. A value of 4'b1111 clears ud_o.
- R11: exc_o is the bitwise OR of the exception flags of the written lanes only. Lanes that are unwritten or above the vector length contribute nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Capture strobe for the operation |
| vl_sel_i | input | 2 | Vector length select |
| mask_en_i | input | 1 | Write mask in use |
| mask_i | input | 8 | Per-lane write mask |
| zero_mode_i | input | 1 | 1 = zeroing masking, 0 = merging masking |
| bcast_i | input | 1 | Broadcast of element 0 requested |
| src_mem_i | input | 1 | Source operand comes from memory |
| rsvd_i | input | 4 | Reserved operand field, must be 4'b1111 |
| old_dst_i | input | 512 | Previous destination value |
| lane_res_i | input | 512 | Per-lane result words |
| lane_exc_i | input | 16 | Per-lane exception flags, 2 bits per lane |
| valid_o | output | 1 | Result valid pulse |
| dst_o | output | 512 | Assembled destination |
| exc_o | output | 2 | OR of written lanes' exception flags |
| ud_o | output | 1 | Undefined-instruction fault |

## Verification
All results pass through one register stage. The destination, the flags and the fault bit of an operation are therefore due at the first clock edge after the strobe. The bench drives inputs on falling edges and samples half a cycle after that rising edge. It checks every lane against a value it computes from the lane count, mask, masking mode and broadcast qualifiers. One cycle later it samples again to confirm that the pulse has dropped and the data has held.

// File: rtl/vlw_pkg.sv
package vlw_pkg;
  typedef enum logic [1:0] {
    VL_128 = 2'd0,
    VL_256 = 2'd1,
    VL_512 = 2'd2,
    VL_512B = 2'd3
  } vl_e;

  function automatic int vl_lanes(input logic [1:0] sel, input int max_lanes);
    int n;
    case (vl_e'(sel))
      VL_128:  n = 2;
      VL_256:  n = 4;
      default: n = 8;
    endcase
    return (n > max_lanes) ? max_lanes : n;
  endfunction
endpackage

// File: rtl/vlw_lane_ctl.sv
module vlw_lane_ctl
  import vlw_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [1:0]       vl_sel_i,
  input  logic             mask_en_i,
  input  logic [LANES-1:0] mask_i,
  output logic [LANES-1:0] active_o,
  output logic [LANES-1:0] wr_o
);
  int lane_cnt;
  always_comb lane_cnt = vl_lanes(vl_sel_i, LANES);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign active_o[j] = (j < lane_cnt);
    assign wr_o[j]     = active_o[j] & (~mask_en_i | mask_i[j]);
  end
endmodule

// File: rtl/vlw_lane_data.sv
module vlw_lane_data #(
  parameter int LANES  = 8,
  parameter int LANE_W = 64,
  parameter int EXC_W  = 2,
  localparam int VW = LANES * LANE_W,
  localparam int XW = LANES * EXC_W
) (
  input  logic             bcast_i,
  input  logic             zero_mode_i,
  input  logic [LANES-1:0] active_i,
  input  logic [LANES-1:0] wr_i,
  input  logic [VW-1:0]    old_i,
  input  logic [VW-1:0]    res_i,
  input  logic [XW-1:0]    exc_i,
  output logic [VW-1:0]    dst_o,
  output logic [EXC_W-1:0] exc_o
);
  logic [XW-1:0] exc_gated;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] src;
    logic [EXC_W-1:0]  flg;
    // broadcast: lane 0 result stands in for every lane
    assign src = bcast_i ? res_i[LANE_W-1:0] : res_i[j*LANE_W +: LANE_W];
    assign flg = bcast_i ? exc_i[EXC_W-1:0]  : exc_i[j*EXC_W +: EXC_W];

    always_comb begin
      if (!active_i[j])     dst_o[j*LANE_W +: LANE_W] = '0;
      else if (wr_i[j])     dst_o[j*LANE_W +: LANE_W] = src;
      else if (zero_mode_i) dst_o[j*LANE_W +: LANE_W] = '0;
      else                  dst_o[j*LANE_W +: LANE_W] = old_i[j*LANE_W +: LANE_W];
    end

    assign exc_gated[j*EXC_W +: EXC_W] = wr_i[j] ? flg : '0;
  end

  always_comb begin
    exc_o = '0;
    for (int j = 0; j < LANES; j++) exc_o |= exc_gated[j*EXC_W +: EXC_W];
  end
endmodule

// File: rtl/vec_lane_wb.sv
module vec_lane_wb #(
  parameter int LANES  = 8,
  parameter int LANE_W = 64,
  parameter int EXC_W  = 2,
  parameter int RSV_W  = 4,
  localparam int VW = LANES * LANE_W,
  localparam int XW = LANES * EXC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       vl_sel_i,
  input  logic             mask_en_i,
  input  logic [LANES-1:0] mask_i,
  input  logic             zero_mode_i,
  input  logic             bcast_i,
  input  logic             src_mem_i,
  input  logic [RSV_W-1:0] rsvd_i,
  input  logic [VW-1:0]    old_dst_i,
  input  logic [VW-1:0]    lane_res_i,
  input  logic [XW-1:0]    lane_exc_i,
  output logic             valid_o,
  output logic [VW-1:0]    dst_o,
  output logic [EXC_W-1:0] exc_o,
  output logic             ud_o
);
  logic [LANES-1:0] active, wr;
  logic [VW-1:0]    dst_n;
  logic [EXC_W-1:0] exc_n;
  logic             fault;

  assign fault = (rsvd_i != {RSV_W{1'b1}});

  vlw_lane_ctl #(.LANES(LANES)) u_ctl (
    .vl_sel_i  (vl_sel_i),
    .mask_en_i (mask_en_i),
    .mask_i    (mask_i),
    .active_o  (active),
    .wr_o      (wr)
  );

  vlw_lane_data #(.LANES(LANES), .LANE_W(LANE_W), .EXC_W(EXC_W)) u_data (
    .bcast_i     (bcast_i & src_mem_i),
    .zero_mode_i (zero_mode_i & mask_en_i),
    .active_i    (active),
    .wr_i        (wr),
    .old_i       (old_dst_i),
    .res_i       (lane_res_i),
    .exc_i       (lane_exc_i),
    .dst_o       (dst_n),
    .exc_o       (exc_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dst_o   <= '0;
      exc_o   <= '0;
      ud_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        dst_o <= fault ? old_dst_i : dst_n;
        exc_o <= fault ? '0 : exc_n;
        ud_o  <= fault;
      end
    end
  end

  a_r2_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(dst_o) && $stable(exc_o) && $stable(ud_o)));
  a_r10_fault_keeps_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rsvd_i != {RSV_W{1'b1}}) |=>
      (ud_o && dst_o == $past(old_dst_i) && exc_o == '0));
  a_r4_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rsvd_i == {RSV_W{1'b1}} && vl_sel_i == 2'd0) |=>
      (dst_o[VW-1:2*LANE_W] == '0));
endmodule

// File: tb/sim_vec_lane_wb.sv
`timescale 1ns/1ps
module sim_vec_lane_wb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   vl_sel_i = '0;
  logic         mask_en_i = 1'b0;
  logic [7:0]   mask_i = '0;
  logic         zero_mode_i = 1'b0;
  logic         bcast_i = 1'b0;
  logic         src_mem_i = 1'b0;
  logic [3:0]   rsvd_i = 4'hF;
  logic [511:0] old_dst_i = '0;
  logic [511:0] lane_res_i = '0;
  logic [15:0]  lane_exc_i = '0;
  logic         valid_o;
  logic [511:0] dst_o;
  logic [1:0]   exc_o;
  logic         ud_o;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  vec_lane_wb u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .vl_sel_i(vl_sel_i),
    .mask_en_i(mask_en_i), .mask_i(mask_i), .zero_mode_i(zero_mode_i),
    .bcast_i(bcast_i), .src_mem_i(src_mem_i), .rsvd_i(rsvd_i),
    .old_dst_i(old_dst_i), .lane_res_i(lane_res_i), .lane_exc_i(lane_exc_i),
    .valid_o(valid_o), .dst_o(dst_o), .exc_o(exc_o), .ud_o(ud_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] res_word(input int k, input int it);
    return {16'hC0DE, 8'(k), 8'(it), 32'(it * 40503) ^ 32'(k)};
  endfunction
  function automatic logic [63:0] old_word(input int k, input int it);
    return {16'h0DD0, 8'(k), 8'(it), 32'hFFFF0000 ^ 32'(it)};
  endfunction
  function automatic logic [1:0] exc_word(input int k, input int it);
    return 2'((k * 7 + it) % 4);
  endfunction

  task automatic load(input int it);
    for (int k = 0; k < 8; k++) begin
      lane_res_i[k*64 +: 64] = res_word(k, it);
      old_dst_i[k*64 +: 64]  = old_word(k, it);
      lane_exc_i[k*2 +: 2]   = exc_word(k, it);
    end
  endtask

  // one capture; checks at the sample point one edge later, then the hold cycle
  task automatic run_op(input int it, input logic [1:0] vl, input logic men, input logic [7:0] m,
                        input logic zm, input logic bc, input logic mem);
    int lanes;
    logic [1:0] eexc;
    logic [511:0] snap;
    @(negedge clk);
    load(it);
    vl_sel_i = vl; mask_en_i = men; mask_i = m; zero_mode_i = zm;
    bcast_i = bc; src_mem_i = mem; rsvd_i = 4'hF; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    lanes = (vl == 2'd0) ? 2 : (vl == 2'd1) ? 4 : 8;
    eexc = '0;
    chk(valid_o === 1'b1, "R2 valid pulse", 64'(valid_o), 64'd1);
    chk(ud_o === 1'b0, "R10 no fault", 64'(ud_o), 64'd0);
    for (int j = 0; j < 8; j++) begin
      logic [63:0] exp;
      logic w;
      int idx;
      string tag;
      idx = (bc && mem) ? 0 : j;
      w = (j < lanes) && (!men || m[j]);
      if (j >= lanes) begin exp = '0; tag = "R3,R4 above length"; end
      else if (w) begin
        exp = res_word(idx, it);
        eexc |= exc_word(idx, it);
        tag = (bc && mem) ? "R9 broadcast" : (bc ? "R9 broadcast ignored" : (men ? "R3,R6 masked write" : "R5 unmasked write"));
      end
      else if (zm) begin exp = '0; tag = "R8 zeroing"; end
      else begin exp = old_word(j, it); tag = "R7 merging"; end
      chk(dst_o[j*64 +: 64] === exp, tag, dst_o[j*64 +: 64], exp);
    end
    chk(exc_o === eexc, "R11 flag OR", 64'(exc_o), 64'(eexc));
    snap = dst_o;
    @(negedge clk);
    chk(valid_o === 1'b0 && dst_o === snap, "R2 single pulse and hold", 64'(valid_o), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int it;
    it = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(valid_o === 1'b0 && ud_o === 1'b0, "R1 reset flags", {62'd0, valid_o, ud_o}, 64'd0);
    chk(dst_o === '0 && exc_o === '0, "R1 reset data", dst_o[63:0], 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid_o === 1'b0, "R2 idle after reset", 64'(valid_o), 64'd0);

    for (int vl = 0; vl < 4; vl++)
      for (int men = 0; men < 2; men++)
        for (int zm = 0; zm < 2; zm++)
          for (int b = 0; b < 4; b++)
            for (int m = 0; m < 256; m++) begin
              run_op(it, 2'(vl), men[0], 8'(m), zm[0], b[0], b[1]);
              it++;
            end

    // R10 reserved field sweep
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      load(it);
      vl_sel_i = 2'd0; mask_en_i = 1'b1; mask_i = 8'h01; zero_mode_i = 1'b1;
      bcast_i = 1'b0; src_mem_i = 1'b0; rsvd_i = 4'(r); valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
      if (r != 15) begin
        chk(ud_o === 1'b1, "R10 fault raised", 64'(ud_o), 64'd1);
        chk(dst_o === old_dst_i, "R10 write suppressed", dst_o[127:64], old_dst_i[127:64]);
        chk(exc_o === 2'b00, "R10 flags cleared", 64'(exc_o), 64'd0);
      end else begin
        chk(ud_o === 1'b0, "R10 fault clear", 64'(ud_o), 64'd0);
        chk(dst_o[63:0] === res_word(0, it) && dst_o[511:64] === '0, "R10 normal write", dst_o[63:0], res_word(0, it));
      end
      it++;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule